// File: doc/BRIEF.md
# SASI Host Handshake Bridge

This block sits between an 8-bit host I/O bus and a SASI-style disk peripheral bus. The host reaches it through four byte registers at a strappable base address. One register moves command, data and status bytes to and from the peripheral data lines. One register samples the peripheral's status lines and drives the host-owned control lines. Two setup registers hold the drive and interrupt options. The peripheral side is active low at the pins.

The block finishes each REQ/ACK handshake on its own when auto-acknowledge is enabled. Any access to the data register raises ACK. ACK stays up until the peripheral drops REQ and is then released. A ready line rises when the peripheral raises a request and falls when the host reads the data register. This lets an external DMA engine stream bytes without software touching ACK. An optional interrupt marks the same request edge, so both polled and interrupt-driven transfers work.

Top module: `sasi_host_bridge`

## Requirements
- R1: The block answers only when `{bus_addr[7:2], bus_ioexp}` equals `base_strap` (strap bit 6 ↔ address bit 7, strap bit 0 ↔ `bus_ioexp`). `bus_addr[1:0]` selects the register: 0 data, 1 status/control, 2 data setup, 3 status setup. Accesses that do not match change no register.
- R2: Reading the status/control register returns, from bit 7 down to bit 0: RST, SEL, ACK, BSY, MSG, C/D, REQ, I/O. A bit reads 1 when its signal is asserted, meaning its pin is low. Input bits reflect the pins one clock after they change.
- R3: Writing the status/control register sets the software RST, SEL and ACK from `bus_wdata[7:5]`. Each pin `p_rst_n`, `p_sel_n`, `p_ack_n` is low while its bit is 1. The input bits [4:0] of the write are ignored.
- R4: Read data appears on `bus_rdata` at the clock edge that samples `bus_rd`. It holds until the next matching read. Setup registers read back the value last written.
- R5: When REQ becomes asserted while I/O is asserted (peripheral to host), the byte on `p_db_in` is latched. A data-register read returns the latched byte. A REQ edge with I/O negated leaves the latched byte unchanged.
- R6: The host drives the peripheral data bus (`p_db_oe`=1, `p_db_out` = last byte written to the data register) only when I/O is negated and data-setup bit 0 is 0. Otherwise the bus is released.
- R7: `dma_ready` rises two clocks after `p_req_n` falls. It clears on a data-register read. A new REQ edge in the same cycle wins.
- R8: With `auto_ack_en`=1, any data-register access asserts ACK on the following edge. ACK is held while REQ stays asserted and released two clocks after REQ is negated. With `auto_ack_en`=0, data accesses leave ACK alone.
- R9: With status-setup bit 0 set, a REQ assertion edge raises `irq`. Any data-register access clears it. With the bit clear, no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Host I/O address |
| bus_ioexp | input | 1 | Host I/O expansion select, matched as strap bit 0 |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered host read data |
| base_strap | input | 7 | Required level of A7..A2 and I/O expansion |
| auto_ack_en | input | 1 | Enables hardware ACK sequencing |
| p_db_in | input | 8 | Peripheral data bus, input side (true polarity) |
| p_db_out | output | 8 | Peripheral data bus, output side |
| p_db_oe | output | 1 | Drive enable for the peripheral data bus |
| p_bsy_n | input | 1 | Peripheral busy, active low |
| p_msg_n | input | 1 | Message phase, active low |
| p_cd_n | input | 1 | Command/data phase, active low |
| p_req_n | input | 1 | Transfer request, active low |
| p_io_n | input | 1 | Direction, low = peripheral to host |
| p_rst_n | output | 1 | Peripheral reset, active low |
| p_sel_n | output | 1 | Peripheral select, active low |
| p_ack_n | output | 1 | Request acknowledge, active low |
| dma_ready | output | 1 | External ready for a DMA engine |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are one-cycle strobes that never occur in the same cycle. They also assume that peripheral pins change only between clock edges. The bench drives every input on the falling clock edge and keeps each strobe high for exactly one cycle. It changes REQ only while no data-register access is in flight, so a request edge and a read do not collide unless a test intends it.

// File: rtl/sasi_pkg.sv
package sasi_pkg;
  typedef enum logic [1:0] {
    RSEL_DATA = 2'd0,
    RSEL_STAT = 2'd1,
    RSEL_DSET = 2'd2,
    RSEL_SSET = 2'd3
  } reg_sel_e;

  localparam int NREGS = 4;
  localparam int STAT_W = 5;
endpackage

// File: rtl/sasi_addr_dec.sv
module sasi_addr_dec #(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr,
  input  logic          ioexp,
  input  logic [AW-2:0] strap,
  input  logic          rd,
  input  logic          wr,
  output logic [sasi_pkg::NREGS-1:0] rd_sel,
  output logic [sasi_pkg::NREGS-1:0] wr_sel
);
  logic hit;
  assign hit = ({addr[AW-1:2], ioexp} == strap);

  for (genvar g = 0; g < sasi_pkg::NREGS; g++) begin : g_sel
    assign rd_sel[g] = hit && rd && (addr[1:0] == 2'(g));
    assign wr_sel[g] = hit && wr && (addr[1:0] == 2'(g));
  end
endmodule

// File: rtl/sasi_ack_seq.sv
module sasi_ack_seq (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic req_a,
  output logic ack_auto
);
  always_ff @(posedge clk) begin
    if (rst) ack_auto <= 1'b0;
    else if (start) ack_auto <= 1'b1;
    else if (ack_auto && !req_a) ack_auto <= 1'b0;
  end

  // R8
  ack_start_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> ack_auto);
  // R8
  ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_auto && req_a) |=> ack_auto);
  // R8
  ack_release_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_auto && !req_a && !start) |=> !ack_auto);
endmodule

// File: rtl/sasi_event_gen.sv
module sasi_event_gen (
  input  logic clk,
  input  logic rst,
  input  logic req_a,
  input  logic ien,
  input  logic data_rd,
  input  logic data_acc,
  output logic req_rise,
  output logic ready,
  output logic irq
);
  logic req_d;

  always_ff @(posedge clk) begin
    if (rst) req_d <= 1'b0;
    else req_d <= req_a;
  end
  assign req_rise = req_a && !req_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (req_rise) ready <= 1'b1;
      else if (data_rd) ready <= 1'b0;
      if (req_rise && ien) irq <= 1'b1;
      else if (data_acc) irq <= 1'b0;
    end
  end

  // R7
  ready_set_chk: assert property (@(posedge clk) disable iff (rst)
    req_rise |=> ready);
  // R7
  ready_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !req_rise) |=> !ready);
  // R9
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (req_rise && ien) |=> irq);
  // R9
  irq_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (data_acc && !(req_rise && ien)) |=> !irq);
endmodule

// File: rtl/sasi_host_bridge.sv
module sasi_host_bridge #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_ioexp,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [AW-2:0] base_strap,
  input  logic          auto_ack_en,
  input  logic [DW-1:0] p_db_in,
  output logic [DW-1:0] p_db_out,
  output logic          p_db_oe,
  input  logic          p_bsy_n,
  input  logic          p_msg_n,
  input  logic          p_cd_n,
  input  logic          p_req_n,
  input  logic          p_io_n,
  output logic          p_rst_n,
  output logic          p_sel_n,
  output logic          p_ack_n,
  output logic          dma_ready,
  output logic          irq
);
  import sasi_pkg::*;

  logic [NREGS-1:0] rd_sel, wr_sel;
  logic [STAT_W-1:0] stat_a;
  logic [DW-1:0] db_s, din_q, dout_q, dset_q, sset_q;
  logic [2:0] ctl_q;
  logic req_rise, ack_auto, ack_all, data_acc, oe_q;

  sasi_addr_dec #(.AW(AW)) u_dec (
    .addr(bus_addr), .ioexp(bus_ioexp), .strap(base_strap),
    .rd(bus_rd), .wr(bus_wr), .rd_sel(rd_sel), .wr_sel(wr_sel)
  );

  // input stage: asserted = 1 (bsy, msg, cd, req, io)
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_a <= '0;
      db_s   <= '0;
    end else begin
      stat_a <= ~{p_bsy_n, p_msg_n, p_cd_n, p_req_n, p_io_n};
      db_s   <= p_db_in;
    end
  end

  assign data_acc = rd_sel[RSEL_DATA] || wr_sel[RSEL_DATA];

  sasi_ack_seq u_ack (
    .clk(clk), .rst(rst), .start(auto_ack_en && data_acc),
    .req_a(stat_a[1]), .ack_auto(ack_auto)
  );

  sasi_event_gen u_evt (
    .clk(clk), .rst(rst), .req_a(stat_a[1]), .ien(sset_q[0]),
    .data_rd(rd_sel[RSEL_DATA]), .data_acc(data_acc),
    .req_rise(req_rise), .ready(dma_ready), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      din_q  <= '0;
      dout_q <= '0;
      dset_q <= '0;
      sset_q <= '0;
      ctl_q  <= '0;
      oe_q   <= 1'b0;
    end else begin
      if (req_rise && stat_a[0]) din_q <= db_s;
      if (wr_sel[RSEL_DATA]) dout_q <= bus_wdata;
      if (wr_sel[RSEL_STAT]) ctl_q <= bus_wdata[DW-1:DW-3];
      if (wr_sel[RSEL_DSET]) dset_q <= bus_wdata;
      if (wr_sel[RSEL_SSET]) sset_q <= bus_wdata;
      oe_q <= !stat_a[0] && !dset_q[0];
    end
  end

  assign ack_all = ctl_q[0] || ack_auto;

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (|rd_sel) begin
      unique case (bus_addr[1:0])
        RSEL_DATA: bus_rdata <= din_q;
        RSEL_STAT: bus_rdata <= {ctl_q[2], ctl_q[1], ack_all, stat_a};
        RSEL_DSET: bus_rdata <= dset_q;
        default:   bus_rdata <= sset_q;
      endcase
    end
  end

  assign p_db_out = dout_q;
  assign p_db_oe  = oe_q;
  assign p_rst_n  = !ctl_q[2];
  assign p_sel_n  = !ctl_q[1];
  assign p_ack_n  = !ack_all;

  // R6
  drive_dir_chk: assert property (@(posedge clk) disable iff (rst)
    p_db_oe |-> $past(!stat_a[0]));
  // R1
  miss_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !(|wr_sel)) |=> $stable(sset_q) && $stable(dset_q));
endmodule

// File: tb/sasi_host_bridge_tb_top.sv
module sasi_host_bridge_tb_top;
  localparam int CLK_P = 10;

  logic clk = 0, rst = 1;
  logic [7:0] bus_addr = 0, bus_wdata = 0, p_db_in = 0;
  logic bus_ioexp = 0, bus_rd = 0, bus_wr = 0, auto_ack_en = 0;
  logic [6:0] base_strap = 7'h00;
  logic p_bsy_n = 1, p_msg_n = 1, p_cd_n = 1, p_req_n = 1, p_io_n = 1;
  logic [7:0] bus_rdata, p_db_out;
  logic p_db_oe, p_rst_n, p_sel_n, p_ack_n, dma_ready, irq;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  sasi_host_bridge dut_i (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic x, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_ioexp = x; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic x);
    @(negedge clk);
    bus_addr = a; bus_ioexp = x; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
  endtask

  initial begin
    settle(3);
    rst = 0;
    settle(1);
    chk(p_ack_n && p_sel_n && p_rst_n, "R3 reset pins", {p_rst_n, p_sel_n, p_ack_n}, 3'b111);
    chk(!dma_ready && !irq && bus_rdata == 0, "R7 reset ready/irq", {dma_ready, irq}, 0);

    // R1 / R4: address match sweep with two strap values
    foreach (base_strap[i]) begin end
    for (int s = 0; s < 2; s++) begin
      logic [6:0] st;
      logic [7:0] expv;
      st = (s == 0) ? 7'h00 : 7'h5B;
      base_strap = st;
      wr({st[6:1], 2'b10}, st[0], 8'h00);
      expv = 8'h00;
      for (int c = 0; c < 128; c++) begin
        logic [7:0] v;
        v = {c[6:0], 1'b0} ^ 8'h80;
        wr({c[6:1], 2'b10}, c[0], v);
        if (c[6:0] == st) expv = v;
        rd({st[6:1], 2'b10}, st[0]);
        chk(bus_rdata == expv, "R1 R4 decode", bus_rdata, expv);
      end
    end
    base_strap = 7'h21;
    wr({6'h10, 2'b10}, 1'b1, 8'h00);
    wr({6'h10, 2'b11}, 1'b1, 8'h3C);
    rd({6'h10, 2'b11}, 1'b1);
    chk(bus_rdata == 8'h3C, "R4 status setup readback", bus_rdata, 8'h3C);
    wr({6'h10, 2'b11}, 1'b1, 8'h00);

    // R2 / R3: status sweep over all input patterns
    for (int v = 0; v < 32; v++) begin
      logic [7:0] expv;
      wr({6'h10, 2'b01}, 1'b1, {v[2:0], 5'b11111});
      {p_bsy_n, p_msg_n, p_cd_n, p_req_n, p_io_n} = ~v[4:0];
      settle(1);
      rd({6'h10, 2'b01}, 1'b1);
      expv = {v[2:0], v[4:0]};
      chk(bus_rdata == expv, "R2 status read", bus_rdata, expv);
      chk({p_rst_n, p_sel_n, p_ack_n} == ~v[2:0], "R3 control pins",
          {p_rst_n, p_sel_n, p_ack_n}, ~v[2:0]);
    end
    wr({6'h10, 2'b01}, 1'b1, 8'h00);
    {p_bsy_n, p_msg_n, p_cd_n, p_req_n, p_io_n} = 5'b11111;
    settle(2);
    rd({6'h10, 2'b00}, 1'b1);

    // R5 / R7 / R8: inbound byte with auto-ack
    auto_ack_en = 1;
    p_io_n = 0; p_db_in = 8'h5A; p_req_n = 0;
    settle(2);
    chk(dma_ready, "R7 ready on req", dma_ready, 1);
    rd({6'h10, 2'b00}, 1'b1);
    chk(bus_rdata == 8'h5A, "R5 latched byte", bus_rdata, 8'h5A);
    chk(!dma_ready, "R7 ready cleared by read", dma_ready, 0);
    chk(!p_ack_n, "R8 auto ack asserted", p_ack_n, 0);
    settle(3);
    chk(!p_ack_n, "R8 ack held while req", p_ack_n, 0);
    p_req_n = 1;
    settle(2);
    chk(p_ack_n, "R8 ack released", p_ack_n, 1);

    // R8: disabled auto-ack
    auto_ack_en = 0;
    p_db_in = 8'hA7; p_req_n = 0;
    settle(2);
    rd({6'h10, 2'b00}, 1'b1);
    chk(bus_rdata == 8'hA7, "R5 second byte", bus_rdata, 8'hA7);
    chk(p_ack_n, "R8 no ack when disabled", p_ack_n, 1);
    p_req_n = 1;
    settle(2);

    // R5 / R6: outbound phase
    p_io_n = 1;
    settle(1);
    wr({6'h10, 2'b00}, 1'b1, 8'hC3);
    settle(2);
    chk(p_db_oe && p_db_out == 8'hC3, "R6 drive outbound", {p_db_oe, p_db_out}, {1'b1, 8'hC3});
    p_db_in = 8'h11; p_req_n = 0;
    settle(2);
    p_req_n = 1;
    settle(2);
    rd({6'h10, 2'b00}, 1'b1);
    chk(bus_rdata == 8'hA7, "R5 no latch when outbound", bus_rdata, 8'hA7);
    wr({6'h10, 2'b10}, 1'b1, 8'h01);
    settle(2);
    chk(!p_db_oe, "R6 drive disabled by setup", p_db_oe, 0);
    wr({6'h10, 2'b10}, 1'b1, 8'h00);
    p_io_n = 0;
    settle(3);
    chk(!p_db_oe, "R6 released inbound", p_db_oe, 0);

    // R9: interrupt
    wr({6'h10, 2'b11}, 1'b1, 8'h01);
    p_req_n = 0;
    settle(2);
    chk(irq, "R9 irq on req", irq, 1);
    wr({6'h10, 2'b00}, 1'b1, 8'h00);
    chk(!irq, "R9 irq cleared by access", irq, 0);
    p_req_n = 1;
    settle(2);
    wr({6'h10, 2'b11}, 1'b1, 8'h00);
    p_req_n = 0;
    settle(3);
    chk(!irq, "R9 no irq when disabled", irq, 0);
    p_req_n = 1;
    settle(2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule